// File: doc/BRIEF.md
# Sixteen-Lane Access Coalescer

The block takes one memory request from a group of sixteen lanes and turns it into the smallest set of external memory transactions it can. Each lane brings a valid bit and a byte address, and the whole group shares one element size of 4, 8 or 16 bytes. When the group forms one aligned, contiguous run, the block issues one wide transaction, or two for 16-byte elements. In every other case it issues one transaction per active lane, walking the lanes from lowest to highest.

Requests come in through a valid/ready pair and are accepted only while the block is idle. Transactions go out through a second valid/ready pair that carries an address and a byte count. After the last transaction of a request has been handed off, a one-cycle completion pulse reports how many transactions the request needed and whether it took the wide path.

Top module: `hw_coalescer`

## Requirements
- R1: While reset is held and just after it is released, req_ready_o is 1, txn_valid_o is 0 and done_valid_o is 0.
- R2: With all sixteen lanes active, req_elem_size_i = 0 (4-byte elements), lane k at base + 4k and base a multiple of 64, exactly one transaction is issued at base with txn_bytes_o = 64. The request completes with count 1 and done_coalesced_o = 1.
- R3: With req_elem_size_i = 1 (8-byte elements), lane k at base + 8k and base a multiple of 128, exactly one transaction is issued at base with txn_bytes_o = 128. The request completes with count 1 and the coalesced flag set.
- R4: With req_elem_size_i = 2 or 3 (both mean 16-byte elements), lane k at base + 16k and base a multiple of 256, two transactions of 128 bytes are issued, first at base and then at base + 128. The request completes with count 2 and the coalesced flag set.
- R5: If any active lane misses its slot base + k × size, one transaction per lane is issued in ascending lane order. Each carries that lane's address and txn_bytes_o equal to the element size. The request completes with count 16 and the coalesced flag clear.
- R6: A contiguous pattern whose base is not a multiple of the region size (16 × element size) is issued lane by lane, as in R5.
- R7: If some lanes are inactive, only the active lanes are issued, in ascending lane order, and the reported count equals the number of active lanes. If no lane is active, no transaction is issued and the request completes with count 0.
- R8: While txn_valid_o is 1 and txn_ready_i is 0, the transaction address and size stay unchanged in the next cycle.
- R9: From acceptance until the last transaction has been taken, req_ready_o is 0. A request presented in that time, with any lane contents, has no effect on the transactions issued.
- R10: done_valid_o is high for the single cycle after the last transaction handshake (or the cycle after acceptance, for an empty request), together with done_count_o and done_coalesced_o.
- R11: Every wide transaction (more than 16 bytes) has an address that is a multiple of 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and accepting a request |
| req_lane_valid_i | input | LANES | Per-lane active bits |
| req_lane_addr_i | input | LANES*AW | Lane byte addresses, lane k in bits [k*AW +: AW] |
| req_elem_size_i | input | 2 | Element size: 0 = 4 B, 1 = 8 B, 2 or 3 = 16 B |
| txn_valid_o | output | 1 | Transaction present |
| txn_ready_i | input | 1 | Downstream takes the transaction |
| txn_addr_o | output | AW | Transaction byte address |
| txn_bytes_o | output | $clog2(MAX_BURST)+1 | Transaction size in bytes |
| done_valid_o | output | 1 | One-cycle completion pulse |
| done_count_o | output | $clog2(LANES+1) | Transactions issued for the request |
| done_coalesced_o | output | 1 | Request was served by wide transactions |

## Verification
The hardest case to reach from the ports is a request that is held back at its outputs while a second request is waiting at the input with different lane contents. The block must ignore the waiting request and still complete the first one correctly. The bench gets there by stalling txn_ready_i on alternate cycles while it keeps req_valid_i high with unrelated addresses for the whole time the block is busy. It then compares every issued address and size against the first request. Patterns that are almost coalesced are also covered: two lanes swapped, a base that is off by half a region, and masks with gaps. Each of these must fall back to lane order.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WIDE, ST_LANE} coal_state_e;

  // log2 of the element size in bytes; code 3 aliases 16 B
  function automatic logic [2:0] size_shift(logic [1:0] code);
    case (code)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/coal_classifier.sv
module coal_classifier #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES-1:0]    lane_valid_i,
  input  logic [LANES*AW-1:0] lane_addr_i,
  input  logic [2:0]          shift_i,
  output logic                coalesced_o
);
  logic [AW-1:0]    base;
  logic [AW-1:0]    align_mask;
  logic [LANES-1:0] slot_ok;

  assign base       = lane_addr_i[AW-1:0];
  assign align_mask = (AW'(LANES) << shift_i) - AW'(1);

  for (genvar k = 0; k < LANES; k++) begin : g_slot
    assign slot_ok[k] = lane_addr_i[k*AW +: AW] == base + (AW'(k) << shift_i);
  end

  assign coalesced_o = (&lane_valid_i) && (&slot_ok) && ((base & align_mask) == '0);
endmodule

// File: rtl/coal_lane_pick.sv
module coal_lane_pick #(
  parameter int LANES = 16,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend_i,
  output logic [LW-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = LW'(i);
    end
  end
endmodule

// File: rtl/coal_wide_plan.sv
module coal_wide_plan #(
  parameter int LANES     = 16,
  parameter int MAX_BURST = 128,
  localparam int BW  = $clog2(MAX_BURST) + 1,
  localparam int CW  = $clog2(LANES + 1),
  localparam int RW  = $clog2(LANES * 16) + 1,
  localparam int LGB = $clog2(MAX_BURST)
) (
  input  logic [2:0]    shift_i,
  output logic [BW-1:0] burst_bytes_o,
  output logic [CW-1:0] beats_o
);
  logic [RW-1:0] region;

  assign region = RW'(LANES) << shift_i;

  always_comb begin
    if (region > RW'(MAX_BURST)) begin
      burst_bytes_o = BW'(MAX_BURST);
      beats_o       = CW'(region >> LGB);
    end else begin
      burst_bytes_o = BW'(region);
      beats_o       = CW'(1);
    end
  end
endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer
  import coal_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int AW        = 32,
  parameter int MAX_BURST = 128,
  localparam int CW = $clog2(LANES + 1),
  localparam int BW = $clog2(MAX_BURST) + 1,
  localparam int LW = $clog2(LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [LANES-1:0]    req_lane_valid_i,
  input  logic [LANES*AW-1:0] req_lane_addr_i,
  input  logic [1:0]          req_elem_size_i,
  output logic                txn_valid_o,
  input  logic                txn_ready_i,
  output logic [AW-1:0]       txn_addr_o,
  output logic [BW-1:0]       txn_bytes_o,
  output logic                done_valid_o,
  output logic [CW-1:0]       done_count_o,
  output logic                done_coalesced_o
);
  coal_state_e      state_q;
  logic [LANES-1:0] pend_q;
  logic [AW-1:0]    addr_q [LANES];
  logic [2:0]       shift_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    beat_q;
  logic             done_v_q;
  logic [CW-1:0]    done_cnt_q;
  logic             done_coal_q;

  logic [2:0]       in_shift;
  logic             in_coal;
  logic [BW-1:0]    burst_bytes;
  logic [CW-1:0]    beats;
  logic [LW-1:0]    pick_idx;
  logic [LANES-1:0] pend_left;
  logic             hs;
  logic             last_beat;

  assign in_shift = size_shift(req_elem_size_i);

  coal_classifier #(.LANES(LANES), .AW(AW)) u_class (
    .lane_valid_i (req_lane_valid_i),
    .lane_addr_i  (req_lane_addr_i),
    .shift_i      (in_shift),
    .coalesced_o  (in_coal)
  );

  coal_wide_plan #(.LANES(LANES), .MAX_BURST(MAX_BURST)) u_plan (
    .shift_i       (shift_q),
    .burst_bytes_o (burst_bytes),
    .beats_o       (beats)
  );

  coal_lane_pick #(.LANES(LANES)) u_pick (
    .pend_i (pend_q),
    .idx_o  (pick_idx)
  );

  assign pend_left = pend_q & ~(LANES'(1) << pick_idx);
  assign hs        = txn_valid_o && txn_ready_i;
  assign last_beat = beat_q == beats - CW'(1);

  assign req_ready_o = state_q == ST_IDLE;
  assign txn_valid_o = state_q != ST_IDLE;

  always_comb begin
    if (state_q == ST_WIDE) begin
      txn_addr_o  = addr_q[0] + AW'(beat_q) * AW'(burst_bytes);
      txn_bytes_o = burst_bytes;
    end else begin
      txn_addr_o  = addr_q[pick_idx];
      txn_bytes_o = BW'(1) << shift_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_q      <= '0;
      shift_q     <= '0;
      cnt_q       <= '0;
      beat_q      <= '0;
      done_v_q    <= 1'b0;
      done_cnt_q  <= '0;
      done_coal_q <= 1'b0;
      for (int i = 0; i < LANES; i++) addr_q[i] <= '0;
    end else begin
      done_v_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            for (int i = 0; i < LANES; i++) addr_q[i] <= req_lane_addr_i[i*AW +: AW];
            shift_q <= in_shift;
            cnt_q   <= '0;
            beat_q  <= '0;
            if (in_coal) begin
              state_q <= ST_WIDE;
            end else if (|req_lane_valid_i) begin
              pend_q  <= req_lane_valid_i;
              state_q <= ST_LANE;
            end else begin
              // empty request: complete without any transaction
              done_v_q    <= 1'b1;
              done_cnt_q  <= '0;
              done_coal_q <= 1'b0;
            end
          end
        end
        ST_WIDE: begin
          if (hs) begin
            cnt_q  <= cnt_q + CW'(1);
            beat_q <= beat_q + CW'(1);
            if (last_beat) begin
              state_q     <= ST_IDLE;
              done_v_q    <= 1'b1;
              done_cnt_q  <= cnt_q + CW'(1);
              done_coal_q <= 1'b1;
            end
          end
        end
        ST_LANE: begin
          if (hs) begin
            cnt_q  <= cnt_q + CW'(1);
            pend_q <= pend_left;
            if (pend_left == '0) begin
              state_q     <= ST_IDLE;
              done_v_q    <= 1'b1;
              done_cnt_q  <= cnt_q + CW'(1);
              done_coal_q <= 1'b0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_valid_o     = done_v_q;
  assign done_count_o     = done_cnt_q;
  assign done_coalesced_o = done_coal_q;
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int LANES = 16,
  parameter int AW    = 32,
  parameter int BW    = 8,
  parameter int CW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          txn_valid_o,
  input logic          txn_ready_i,
  input logic [AW-1:0] txn_addr_o,
  input logic [BW-1:0] txn_bytes_o,
  input logic          done_valid_o,
  input logic [CW-1:0] done_count_o,
  input logic          done_coalesced_o
);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && !txn_ready_i |=> txn_valid_o && $stable(txn_addr_o) && $stable(txn_bytes_o));

  assert_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o |-> !req_ready_o);

  assert_wide_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o && done_coalesced_o |-> (done_count_o == CW'(1) || done_count_o == CW'(2)));

  assert_lane_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_o |-> done_count_o <= CW'(LANES));

  assert_wide_align_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_valid_o && txn_bytes_o > BW'(16) |-> txn_addr_o[5:0] == 6'd0);
endmodule

bind hw_coalescer coal_checker #(.LANES(LANES), .AW(AW), .BW(BW), .CW(CW)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_ready_o      (req_ready_o),
  .txn_valid_o      (txn_valid_o),
  .txn_ready_i      (txn_ready_i),
  .txn_addr_o       (txn_addr_o),
  .txn_bytes_o      (txn_bytes_o),
  .done_valid_o     (done_valid_o),
  .done_count_o     (done_count_o),
  .done_coalesced_o (done_coalesced_o)
);

// File: tb/hw_coalescer_tb.sv
module hw_coalescer_tb;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [15:0]   req_lane_valid_i = '0;
  logic [511:0]  req_lane_addr_i = '0;
  logic [1:0]    req_elem_size_i = '0;
  logic          txn_valid_o;
  logic          txn_ready_i = 1'b1;
  logic [31:0]   txn_addr_o;
  logic [7:0]    txn_bytes_o;
  logic          done_valid_o;
  logic [4:0]    done_count_o;
  logic          done_coalesced_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] tb_addr [16];
  logic [31:0] got_addr [32];
  logic [7:0]  got_bytes [32];
  int          got_n;
  int          got_cnt;
  bit          got_coal;
  logic [31:0] exp_addr [16];
  logic [7:0]  exp_bytes [16];
  int          exp_n;
  bit          exp_coal;

  always #2 clk_i = ~clk_i;

  hw_coalescer u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_lane_valid_i, .req_lane_addr_i,
    .req_elem_size_i, .txn_valid_o, .txn_ready_i, .txn_addr_o, .txn_bytes_o,
    .done_valid_o, .done_count_o, .done_coalesced_o
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  // Drive one request, collect transactions until the completion pulse.
  task automatic run_req(input logic [15:0] mask, input logic [1:0] sz, input bit bp, input bit junk, input string tag);
    int cyc = 0;
    int last_hs = 0;
    int done_cyc = -1;
    bit prev_stall = 0;
    bit tgl = 0;
    bit busy_bad = 0;
    bit hold_bad = 0;
    logic [31:0] prev_addr = '0;
    got_n = 0;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, {tag, " R9 idle ready"}, 32'(req_ready_o), 1);
    req_valid_i = 1'b1;
    req_lane_valid_i = mask;
    req_elem_size_i = sz;
    for (int k = 0; k < 16; k++) req_lane_addr_i[k*32 +: 32] = tb_addr[k];
    forever begin
      @(negedge clk_i);
      cyc++;
      if (junk) begin
        req_valid_i = 1'b1;
        req_lane_valid_i = 16'hFFFF;
        for (int k = 0; k < 16; k++) req_lane_addr_i[k*32 +: 32] = 32'h9000_0000 + 32'(k * 4);
      end else begin
        req_valid_i = 1'b0;
      end
      if (done_valid_o) begin
        req_valid_i = 1'b0;
        got_cnt = int'(done_count_o);
        got_coal = done_coalesced_o;
        done_cyc = cyc;
        break;
      end
      if (req_ready_o) busy_bad = 1;
      if (prev_stall && (!txn_valid_o || txn_addr_o != prev_addr)) hold_bad = 1;
      if (txn_valid_o) begin
        txn_ready_i = bp ? tgl : 1'b1;
        tgl = ~tgl;
        if (txn_ready_i && got_n < 32) begin
          got_addr[got_n] = txn_addr_o;
          got_bytes[got_n] = txn_bytes_o;
          got_n++;
          last_hs = cyc;
        end
        prev_stall = !txn_ready_i;
        prev_addr = txn_addr_o;
      end else begin
        prev_stall = 0;
      end
      if (cyc > 200) begin
        req_valid_i = 1'b0;
        break;
      end
    end
    txn_ready_i = 1'b1;
    chk(done_cyc >= 0, {tag, " R10 completion seen"}, 32'(done_cyc), 1);
    chk(done_cyc == last_hs + 1, {tag, " R10 done one cycle after last handshake"},
        32'(done_cyc), 32'(last_hs + 1));
    chk(!busy_bad, {tag, " R9 ready low while busy"}, 32'(busy_bad), 0);
    chk(!hold_bad, {tag, " R8 held under stall"}, 32'(hold_bad), 0);
  endtask

  task automatic check_result(input string tag);
    chk(got_n == exp_n, {tag, " transaction count"}, 32'(got_n), 32'(exp_n));
    chk(got_cnt == exp_n, {tag, " R10 reported count"}, 32'(got_cnt), 32'(exp_n));
    chk(got_coal == exp_coal, {tag, " R10 coalesced flag"}, 32'(got_coal), 32'(exp_coal));
    for (int i = 0; i < exp_n; i++) begin
      if (i < got_n) begin
        chk(got_addr[i] == exp_addr[i], {tag, " address"}, got_addr[i], exp_addr[i]);
        chk(got_bytes[i] == exp_bytes[i], {tag, " size"}, 32'(got_bytes[i]), 32'(exp_bytes[i]));
      end
    end
  endtask

  task automatic fill_linear(input logic [31:0] base, input int stride);
    for (int k = 0; k < 16; k++) tb_addr[k] = base + 32'(k * stride);
  endtask

  task automatic expect_lanes(input logic [15:0] mask, input logic [1:0] sz);
    exp_n = 0;
    exp_coal = 0;
    for (int k = 0; k < 16; k++) begin
      if (mask[k]) begin
        exp_addr[exp_n] = tb_addr[k];
        exp_bytes[exp_n] = (sz == 0) ? 8'd4 : (sz == 1) ? 8'd8 : 8'd16;
        exp_n++;
      end
    end
  endtask

  task automatic test_reset;
    #1;
    chk(req_ready_o == 1'b1, "R1 ready in reset", 32'(req_ready_o), 1);
    chk(txn_valid_o == 1'b0, "R1 no transaction in reset", 32'(txn_valid_o), 0);
    chk(done_valid_o == 1'b0, "R1 no done in reset", 32'(done_valid_o), 0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1 && !txn_valid_o && !done_valid_o, "R1 idle after reset",
        {29'd0, req_ready_o, txn_valid_o, done_valid_o}, 32'h4);
  endtask

  task automatic test_coal4;
    fill_linear(32'h0000_1000, 4);
    exp_n = 1; exp_coal = 1; exp_addr[0] = 32'h0000_1000; exp_bytes[0] = 8'd64;
    run_req(16'hFFFF, 2'd0, 0, 0, "R2");
    check_result("R2 4-byte wide");
  endtask

  task automatic test_coal8;
    fill_linear(32'h0000_2080, 8);
    exp_n = 1; exp_coal = 1; exp_addr[0] = 32'h0000_2080; exp_bytes[0] = 8'd128;
    run_req(16'hFFFF, 2'd1, 0, 0, "R3");
    check_result("R3 8-byte wide");
  endtask

  task automatic test_coal16;
    fill_linear(32'h0000_3100, 16);
    exp_n = 2; exp_coal = 1;
    exp_addr[0] = 32'h0000_3100; exp_bytes[0] = 8'd128;
    exp_addr[1] = 32'h0000_3180; exp_bytes[1] = 8'd128;
    run_req(16'hFFFF, 2'd2, 1, 0, "R4 R8");
    check_result("R4 16-byte two beats stalled R8");
    fill_linear(32'h0000_4000, 16);
    exp_addr[0] = 32'h0000_4000; exp_addr[1] = 32'h0000_4080;
    run_req(16'hFFFF, 2'd3, 0, 0, "R4");
    check_result("R4 size code 3");
  endtask

  task automatic test_scatter;
    fill_linear(32'h0000_5000, 8);
    expect_lanes(16'hFFFF, 2'd0);
    run_req(16'hFFFF, 2'd0, 0, 0, "R5");
    check_result("R5 stride two words");
    fill_linear(32'h0000_6000, 4);
    tb_addr[0] = 32'h0000_6004;
    tb_addr[1] = 32'h0000_6000;
    expect_lanes(16'hFFFF, 2'd0);
    run_req(16'hFFFF, 2'd0, 1, 0, "R5");
    check_result("R5 swapped lanes in lane order");
  endtask

  task automatic test_misalign;
    fill_linear(32'h0000_1020, 4);
    expect_lanes(16'hFFFF, 2'd0);
    run_req(16'hFFFF, 2'd0, 0, 0, "R6");
    check_result("R6 misaligned base");
  endtask

  task automatic test_partial;
    fill_linear(32'h0000_7000, 4);
    expect_lanes(16'hA5A5, 2'd0);
    run_req(16'hA5A5, 2'd0, 0, 0, "R7");
    check_result("R7 partial mask");
    fill_linear(32'h0000_8000, 16);
    expect_lanes(16'h0000, 2'd2);
    run_req(16'h0000, 2'd2, 0, 0, "R7");
    check_result("R7 empty mask");
  endtask

  task automatic test_busy_ignore;
    fill_linear(32'h0000_A000, 12);
    expect_lanes(16'h7FFE, 2'd1);
    run_req(16'h7FFE, 2'd1, 1, 1, "R9");
    check_result("R9 request while busy ignored");
    fill_linear(32'h0000_B000, 4);
    exp_n = 1; exp_coal = 1; exp_addr[0] = 32'h0000_B000; exp_bytes[0] = 8'd64;
    run_req(16'hFFFF, 2'd0, 0, 0, "R9");
    check_result("R9 next request after busy");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_coal4();
    test_coal8();
    test_coal16();
    test_scatter();
    test_misalign();
    test_partial();
    test_busy_ignore();
    repeat (2) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule